// File: doc/BRIEF.md
# System Register Byte-Lane Write Bank

This block receives writes to a small group of processor control registers and
applies each register's own rule for byte-wide stores before the value is
stored. The group has four registers: a software interrupt request word, a
stack boundary word, a memory fault word whose bits are cleared by writing ones,
and a display/data word. A write gives a five-bit byte address, whose upper four
bits choose the register word and whose bit 0 chooses the byte. It also gives
16 bits of data and a flag that marks a byte access. On a byte access the byte
is always carried in data bits 7:0, whichever half it is meant for.

Byte accesses are not merged into the addressed half. Depending on the
register, a byte access is dropped or moved to the upper half with the lower
half cleared. It can also be stored zero-extended. A write to a register word
that is not decoded raises a one-cycle fault flag and changes nothing. The
memory fault word also takes a set-vector from the error sources, and that
vector is ORed in every cycle. Reads and the logic that acts on the stored
values belong to other blocks.

Top module: `sysreg_wbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four register outputs and `bad_reg` become 0.
- R2: A word write (`wr_byte`=0) to word index 13 (byte addresses 0x1A/0x1B) stores `wr_data & 16'hFE00` in `irq_req` at the next edge.
- R3: A byte write to byte address 0x1A (even byte of index 13) or 0x1C (even byte of index 14) leaves `irq_req` and `stack_lim` unchanged.
- R4: A byte write to byte address 0x1B sets `irq_req` to `{wr_data[7:0], 8'h00} & 16'hFE00`.
- R5: At word index 14 (0x1C/0x1D), a word write stores `wr_data & 16'hFF00` in `stack_lim`, and an odd byte write stores `{wr_data[7:0], 8'h00}`.
- R6: `mem_err` takes `mem_err_set` ORed in on every cycle out of reset. A word write to index 2 (0x04/0x05) clears each bit that is 1 in `wr_data`, and no other write changes the word.
- R7: A byte write to 0x05 clears `mem_err` bits 15:8 wherever `wr_data[7:0]` has a 1. A byte write to 0x04 clears bits 7:0 wherever `wr_data[7:0]` has a 1.
- R8: When a clear and a set hit the same `mem_err` bit in one cycle, the bit ends at 1.
- R9: At word index 4 (0x08/0x09), a word write stores all 16 bits in `disp_data` and a byte write to 0x08 stores `{8'h00, wr_data[7:0]}`. A byte write to 0x09 leaves `disp_data` unchanged.
- R10: A write to any word index other than 2, 4, 13 or 14 sets `bad_reg` to 1 for the next cycle and leaves all four registers unchanged apart from the `mem_err_set` OR.
- R11: `bad_reg` is 0 in the cycle after any cycle with no write or with a write to a decoded index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Byte address: bits 4:1 word index, bit 0 byte select |
| wr_data | input | 16 | Write data; on a byte access the byte is in bits 7:0 |
| wr_byte | input | 1 | 1 = byte access, 0 = word access |
| mem_err_set | input | 16 | Error bits to set in the memory fault word |
| irq_req | output | 16 | Software interrupt request word |
| stack_lim | output | 16 | Stack boundary word |
| mem_err | output | 16 | Memory fault word |
| disp_data | output | 16 | Display/data word |
| bad_reg | output | 1 | Pulses 1 for a cycle after a write to an undecoded index |

## Verification
The hardest case to bring about is a cycle in which a write-one clear and an
incoming set hit the same memory fault bits at once, together with odd-byte
clears that have to land on the upper half. The stimulus first loads the fault
word through the set vector. It then issues byte and word clears while the set
vector still drives some of the same bits, so that the priority of set over
clear and the lane steering both show up on the output. Ignored byte lanes are
exercised by loading a known value first and then writing the dropped byte with
a contrasting pattern.

// File: rtl/sysreg_pkg.sv
// Shared sizes and slot numbering for the system register write bank.
// Assumes a 16-bit data path and a four-bit word index.
package sysreg_pkg;
    localparam int SR_DW   = 16;
    localparam int SR_IW   = 4;
    localparam int SR_NREG = 4;

    // Slot numbers used to order the per-register tables in the top.
    typedef enum logic [1:0] {
        SLOT_IRQ  = 2'd0,
        SLOT_SLIM = 2'd1,
        SLOT_MERR = 2'd2,
        SLOT_DISP = 2'd3
    } sr_slot_e;
endpackage

// File: rtl/sysreg_dec.sv
// Word-index decoder: compares the index against every register slot and
// produces one select per slot plus a hit flag. Assumes the indices in
// IDX_PACK are all different.
module sysreg_dec #(
    parameter int IW   = 4,
    parameter int NREG = 4,
    parameter logic [NREG*IW-1:0] IDX_PACK = '0
) (
    input  logic [IW-1:0]   idx,
    input  logic            wr_en,
    output logic [NREG-1:0] sel,
    output logic            hit
);
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_cmp
            // One comparator per slot.
            assign sel[g] = wr_en && (idx == IDX_PACK[g*IW +: IW]);
        end
    endgenerate

    // Any slot matched.
    assign hit = |sel;
endmodule

// File: rtl/sysreg_lane.sv
// Byte-lane steering for one register. From the access type and byte select
// it decides whether the write goes ahead and which 16-bit value it carries.
// Assumes the byte of a byte access sits in data bits HB-1:0.
module sysreg_lane #(
    parameter int   DW        = 16,
    parameter logic DROP_EVEN = 1'b0,
    parameter logic DROP_ODD  = 1'b0,
    parameter logic SHIFT_ODD = 1'b0
) (
    input  logic          sel,
    input  logic          byte_acc,
    input  logic          odd,
    input  logic [DW-1:0] data,
    output logic          upd,
    output logic [DW-1:0] val
);
    localparam int HB = DW / 2;

    logic dropped;

    // Byte accesses to a dropped lane never reach the register.
    always_comb begin
        dropped = byte_acc && ((odd && DROP_ODD) || (!odd && DROP_EVEN));
        upd     = sel && !dropped;
    end

    // Align the value: full word, odd byte moved up, or byte zero-extended.
    always_comb begin
        if (!byte_acc)
            val = data;
        else if (odd && SHIFT_ODD)
            val = {data[HB-1:0], {HB{1'b0}}};
        else
            val = {{HB{1'b0}}, data[HB-1:0]};
    end
endmodule

// File: rtl/sysreg_cell.sv
// Storage for one register: either a plain masked load or a write-ones-to-
// clear word with an OR-in set vector (set wins over clear). Synchronous
// active-low reset to zero.
module sysreg_cell #(
    parameter int            DW    = 16,
    parameter logic          W1C   = 1'b0,
    parameter logic [DW-1:0] WMASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [DW-1:0] wval,
    input  logic [DW-1:0] set_bits,
    output logic [DW-1:0] q
);
    generate
        if (W1C) begin : g_w1c
            logic [DW-1:0] clr;
            // Bits to clear this cycle.
            assign clr = upd ? (wval & WMASK) : '0;
            // Clear written ones, then OR in the error sources.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= (q & ~clr) | set_bits;
            end
        end else begin : g_plain
            logic unused_set;
            assign unused_set = ^set_bits;
            // Masked load on an accepted write.
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= '0;
                else if (upd) q <= wval & WMASK;
            end
        end
    endgenerate
endmodule

// File: rtl/sysreg_wbank.sv
// Top of the system register write bank. Splits the byte address into word
// index and byte select, decodes the index, steers each register's byte lane
// by its own rule, stores the result, and flags writes to undecoded words.
// Assumes one write per cycle at most; reads happen elsewhere.
module sysreg_wbank
    import sysreg_pkg::*;
#(
    parameter int              DW         = SR_DW,
    parameter int              IW         = SR_IW,
    parameter logic [IW-1:0]   IDX_IRQ    = 4'd13,
    parameter logic [IW-1:0]   IDX_SLIM   = 4'd14,
    parameter logic [IW-1:0]   IDX_MERR   = 4'd2,
    parameter logic [IW-1:0]   IDX_DISP   = 4'd4,
    parameter logic [DW-1:0]   IRQ_WMASK  = 16'hFE00,
    parameter logic [DW-1:0]   SLIM_WMASK = 16'hFF00,
    parameter logic [DW-1:0]   DISP_WMASK = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW:0]   wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_byte,
    input  logic [DW-1:0] mem_err_set,
    output logic [DW-1:0] irq_req,
    output logic [DW-1:0] stack_lim,
    output logic [DW-1:0] mem_err,
    output logic [DW-1:0] disp_data,
    output logic          bad_reg
);
    localparam int NREG = SR_NREG;

    // Per-slot tables, slot order IRQ, SLIM, MERR, DISP (bit 0 first).
    localparam logic [NREG*IW-1:0] IDX_PACK = {IDX_DISP, IDX_MERR, IDX_SLIM, IDX_IRQ};
    localparam logic [NREG*DW-1:0] MASK_PACK = {DISP_WMASK, {DW{1'b1}}, SLIM_WMASK, IRQ_WMASK};
    localparam logic [NREG-1:0] DROP_EVEN_T = 4'b0011;
    localparam logic [NREG-1:0] DROP_ODD_T  = 4'b1000;
    localparam logic [NREG-1:0] SHIFT_ODD_T = 4'b0111;
    localparam logic [NREG-1:0] W1C_T       = 4'b0100;

    logic [IW-1:0]   idx;
    logic            odd;
    logic [NREG-1:0] sel;
    logic            hit;
    logic            bad_q;
    logic [DW-1:0]   q [NREG];

    // Split the byte address.
    assign idx = wr_addr[IW:1];
    assign odd = wr_addr[0];

    sysreg_dec #(
        .IW      (IW),
        .NREG    (NREG),
        .IDX_PACK(IDX_PACK)
    ) u_dec (
        .idx  (idx),
        .wr_en(wr_en),
        .sel  (sel),
        .hit  (hit)
    );

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            logic          upd;
            logic [DW-1:0] val;
            logic [DW-1:0] setv;

            sysreg_lane #(
                .DW       (DW),
                .DROP_EVEN(DROP_EVEN_T[g]),
                .DROP_ODD (DROP_ODD_T[g]),
                .SHIFT_ODD(SHIFT_ODD_T[g])
            ) u_lane (
                .sel     (sel[g]),
                .byte_acc(wr_byte),
                .odd     (odd),
                .data    (wr_data),
                .upd     (upd),
                .val     (val)
            );

            // Only the write-ones-to-clear word sees the error sources.
            assign setv = W1C_T[g] ? mem_err_set : '0;

            sysreg_cell #(
                .DW   (DW),
                .W1C  (W1C_T[g]),
                .WMASK(MASK_PACK[g*DW +: DW])
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .upd     (upd),
                .wval    (val),
                .set_bits(setv),
                .q       (q[g])
            );
        end
    endgenerate

    // Flag a write that matched no register.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_q <= 1'b0;
        else        bad_q <= wr_en && !hit;
    end

    // Drive the register outputs from their slots.
    assign irq_req   = q[SLOT_IRQ];
    assign stack_lim = q[SLOT_SLIM];
    assign mem_err   = q[SLOT_MERR];
    assign disp_data = q[SLOT_DISP];
    assign bad_reg   = bad_q;
endmodule

// File: rtl/sysreg_wbank_chk.sv
// Property checker for sysreg_wbank, attached with bind below.
module sysreg_wbank_chk #(
    parameter int            DW       = 16,
    parameter int            IW       = 4,
    parameter logic [IW-1:0] IDX_IRQ  = 4'd13,
    parameter logic [IW-1:0] IDX_SLIM = 4'd14,
    parameter logic [IW-1:0] IDX_MERR = 4'd2,
    parameter logic [IW-1:0] IDX_DISP = 4'd4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [IW:0]   wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_byte,
    input logic [DW-1:0] mem_err_set,
    input logic [DW-1:0] irq_req,
    input logic [DW-1:0] stack_lim,
    input logic [DW-1:0] mem_err,
    input logic [DW-1:0] disp_data,
    input logic          bad_reg
);
    localparam int HB = DW / 2;

    logic [IW-1:0] idx;
    logic          known;
    assign idx   = wr_addr[IW:1];
    assign known = (idx == IDX_IRQ) || (idx == IDX_SLIM) ||
                   (idx == IDX_MERR) || (idx == IDX_DISP);

    assert_irq_even_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && !wr_addr[0] && idx == IDX_IRQ) |=> $stable(irq_req));

    assert_slim_odd_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && wr_addr[0] && idx == IDX_SLIM)
        |=> (stack_lim == {$past(wr_data[HB-1:0]), {HB{1'b0}}}));

    assert_merr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_err_set == '0 && !(wr_en && idx == IDX_MERR)) |=> $stable(mem_err));

    assert_merr_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_err_set != '0) |=> ((mem_err & $past(mem_err_set)) == $past(mem_err_set)));

    assert_disp_odd_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && wr_addr[0] && idx == IDX_DISP) |=> $stable(disp_data));

    assert_bad_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !known) |=> (bad_reg && $stable(irq_req) &&
                               $stable(stack_lim) && $stable(disp_data)));

    assert_bad_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !known) |=> !bad_reg);
endmodule

bind sysreg_wbank sysreg_wbank_chk #(
    .DW      (DW),
    .IW      (IW),
    .IDX_IRQ (IDX_IRQ),
    .IDX_SLIM(IDX_SLIM),
    .IDX_MERR(IDX_MERR),
    .IDX_DISP(IDX_DISP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_byte    (wr_byte),
    .mem_err_set(mem_err_set),
    .irq_req    (irq_req),
    .stack_lim  (stack_lim),
    .mem_err    (mem_err),
    .disp_data  (disp_data),
    .bad_reg    (bad_reg)
);

// File: tb/tb_sysreg_wbank.sv
`timescale 1ns/1ps
module tb_sysreg_wbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_byte = 1'b0;
    logic [15:0] mem_err_set = '0;
    logic [15:0] irq_req, stack_lim, mem_err, disp_data;
    logic        bad_reg;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] irq, slim, merr, disp;
        logic        bad;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // Bench-side model state
    logic [15:0] m_irq = '0, m_slim = '0, m_merr = '0, m_disp = '0;

    sysreg_wbank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_byte(wr_byte), .mem_err_set(mem_err_set),
        .irq_req(irq_req), .stack_lim(stack_lim), .mem_err(mem_err),
        .disp_data(disp_data), .bad_reg(bad_reg)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic drive(input logic en, input logic [4:0] a, input logic [15:0] d,
                         input logic b, input logic [15:0] s, input string tag);
        exp_t e;
        logic [15:0] clr;
        logic bad;
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; wr_byte = b; mem_err_set = s;
        clr = '0; bad = 1'b0;
        if (en) begin
            case (a[4:1])
                4'd13: if (!b) m_irq = d & 16'hFE00;
                       else if (a[0]) m_irq = {d[7:0], 8'h00} & 16'hFE00;
                4'd14: if (!b) m_slim = d & 16'hFF00;
                       else if (a[0]) m_slim = {d[7:0], 8'h00};
                4'd2:  clr = !b ? d : (a[0] ? {d[7:0], 8'h00} : {8'h00, d[7:0]});
                4'd4:  if (!b) m_disp = d;
                       else if (!a[0]) m_disp = {8'h00, d[7:0]};
                default: bad = 1'b1;
            endcase
        end
        m_merr = (m_merr & ~clr) | s;
        e.irq = m_irq; e.slim = m_slim; e.merr = m_merr; e.disp = m_disp;
        e.bad = bad; e.due = cyc + 1; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic b,
                      input string tag);
        drive(1'b1, a, d, b, 16'h0000, tag);
    endtask

    // Monitor: compares the design against the oldest due expectation.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (irq_req !== e.irq || stack_lim !== e.slim || mem_err !== e.merr ||
                disp_data !== e.disp || bad_reg !== e.bad) begin
                failures++;
                $display("FAIL %s: actual irq=%h slim=%h merr=%h disp=%h bad=%b expected irq=%h slim=%h merr=%h disp=%h bad=%b",
                         e.tag, irq_req, stack_lim, mem_err, disp_data, bad_reg,
                         e.irq, e.slim, e.merr, e.disp, e.bad);
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        // R1: reset with a pending write to an undecoded index
        wr_en = 1'b1; wr_addr = 5'h00; wr_data = 16'hFFFF; mem_err_set = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({irq_req, stack_lim, mem_err, disp_data} !== '0 || bad_reg !== 1'b0) begin
            failures++;
            $display("FAIL R1: actual irq=%h slim=%h merr=%h disp=%h bad=%b expected all zero",
                     irq_req, stack_lim, mem_err, disp_data, bad_reg);
        end
        wr_en = 1'b0; mem_err_set = '0;
        rst_n = 1'b1;

        drive(1'b0, 5'h00, 16'h0000, 1'b0, 16'h0000, "R11 idle");
        wr(5'h1A, 16'hFFFF, 1'b0, "R2 word irq");
        wr(5'h1B, 16'hA5C3, 1'b0, "R2 word irq odd addr");
        wr(5'h1A, 16'h00FF, 1'b1, "R3 even byte irq ignored");
        wr(5'h1B, 16'h1234, 1'b1, "R4 odd byte irq shifted");
        wr(5'h1B, 16'h00FF, 1'b1, "R4 odd byte irq masked");
        wr(5'h1C, 16'hBEEF, 1'b0, "R5 word slim");
        wr(5'h1C, 16'h0042, 1'b1, "R3 even byte slim ignored");
        wr(5'h1D, 16'hFF7E, 1'b1, "R5 odd byte slim");
        drive(1'b0, 5'h00, 16'h0, 1'b0, 16'hF0F0, "R6 set OR");
        drive(1'b0, 5'h00, 16'h0, 1'b0, 16'h0F0F, "R6 set OR again");
        wr(5'h04, 16'h8001, 1'b0, "R6 word clear");
        wr(5'h1A, 16'hFFFF, 1'b1, "R6 other write no effect");
        wr(5'h05, 16'h00F0, 1'b1, "R7 odd byte clear high");
        wr(5'h04, 16'hFF0F, 1'b1, "R7 even byte clear low");
        drive(1'b1, 5'h04, 16'hFFFF, 1'b0, 16'h0180, "R8 set beats clear");
        drive(1'b1, 5'h05, 16'h0081, 1'b1, 16'h8000, "R8 set beats odd clear");
        wr(5'h08, 16'hC0DE, 1'b0, "R9 word disp");
        wr(5'h09, 16'h0011, 1'b1, "R9 odd byte disp ignored");
        wr(5'h08, 16'hAB5A, 1'b1, "R9 even byte disp");
        wr(5'h00, 16'hFFFF, 1'b0, "R10 undecoded index 0");
        wr(5'h1F, 16'h00FF, 1'b1, "R10 undecoded index 15");
        drive(1'b1, 5'h0C, 16'hFFFF, 1'b0, 16'h0002, "R10 undecoded with set");
        wr(5'h1D, 16'h0001, 1'b1, "R11 decoded after bad");
        drive(1'b0, 5'h00, 16'h0, 1'b0, 16'h0, "R11 idle end");
        repeat (3) @(negedge clk);
        done = 1;
        if (sb.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        summary();
    end
endmodule